// File: doc/BRIEF.md
# Load-Word Execute Unit

This unit carries out one 16-bit load-word instruction for a small coprocessor with eight general-purpose registers. The caller presents an already decoded instruction: the addressing form, the destination, base and index register numbers, a 5-bit unsigned offset and a 16-bit constant. The caller pulses `start` while the unit is idle. The unit then computes the effective address, makes one read on a synchronous memory port, writes the returned word into the destination register and updates the index register where the addressing form requires it.

There are four memory forms: base plus offset, base plus index, base plus index with the index stepped up by two after the read, and base plus index with the index stepped down by two before the read. The constant form reads no memory. It writes the low byte of the constant and then the high byte of the constant in two consecutive cycles. Register 0 always reads as zero. A `done` pulse marks the cycle in which the destination write commits. The register file can be observed through a registered read port. The unit never touches the condition flags, because it has no path to them.

Top module: `ldw_exec_unit`

## Requirements
- R1: Mode code 0 (offset form) reads from base register plus the zero-extended 5-bit offset and writes the word to the destination.
- R2: Mode code 1 (indexed form) reads from base plus index and leaves the index register unchanged.
- R3: Mode code 2 (post-step form) reads from base plus the old index, then writes the index back increased by 2.
- R4: Mode code 3 (pre-step form) lowers the index by 2, reads from base plus the lowered index and leaves the lowered value in the index register.
- R5: In the post-step form with index equal to destination, the destination ends holding the loaded word and no step is applied.
- R6: Mode code 4 (constant form) writes constant bits 7:0 into the low byte of the destination one cycle before it writes bits 15:8 into the high byte, and it issues no memory read.
- R7: Register 0 reads as zero after any write. A load aimed at register 0 still makes its memory read.
- R8: Address sums and index steps wrap modulo 2^16.
- R9: An odd effective address is placed on the memory port unchanged.
- R10: `mem_rd_en` is high for exactly one cycle, two cycles after the accepting edge. `done` is high for one cycle, in the write-back cycle: 3 cycles after `start` is sampled for memory forms and 2 cycles for the constant form.
- R11: `start` is ignored while `busy` is high, and mode codes 5 to 7 are ignored.
- R12: After reset, `busy`, `done` and `mem_rd_en` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the presented instruction (only when idle) |
| mode | input | 3 | Addressing form code (0..4 valid) |
| rd_sel | input | 3 | Destination register number |
| rb_sel | input | 3 | Base register number |
| ri_sel | input | 3 | Index register number |
| offs | input | 5 | Unsigned offset for the offset form |
| imm | input | 16 | Constant for the constant form |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Destination write commits this cycle |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| rf_raddr | input | 3 | Observation read address |
| rf_rdata | output | 16 | Registered observation read data |

## Verification
The bench targets the cases where the index and destination collide or the address leaves the 16-bit range. In the post-step collision, a design that applied the step would leave the loaded word plus two in the destination. A pre-step from zero that failed to wrap, or that stepped after the read, would put the wrong address on the port. The bench samples the destination between the two constant-form cycles to catch a design that writes the bytes in the wrong order or both at once. It also checks that a start pulse given mid-instruction and an undefined mode code leave no read on the port and no change in any register.

// File: rtl/ldw_pkg.sv
package ldw_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_OFFS    = 3'd0,
    AM_IDX     = 3'd1,
    AM_POSTINC = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_IMM     = 3'd4
  } amode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_READ,
    ST_WB,
    ST_IMM_LO,
    ST_IMM_HI
  } st_t;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return m <= 3'd4;
  endfunction

endpackage

// File: rtl/ldw_regfile.sv
module ldw_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG),
  localparam int NB  = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  // port A: destination writes with byte lanes, wins on collision
  input  logic          wa_en,
  input  logic [RW-1:0] wa_addr,
  input  logic [NB-1:0] wa_be,
  input  logic [DW-1:0] wa_data,
  // port B: index write-back
  input  logic          wb_en,
  input  logic [RW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  // combinational read ports
  input  logic [RW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [RW-1:0] rc_addr,
  output logic [DW-1:0] rc_data,
  // registered observation port
  input  logic [RW-1:0] rx_addr,
  output logic [DW-1:0] rx_data
);

  logic [DW-1:0] rows [NREG];

  assign rows[0] = '0;

  for (genvar r = 1; r < NREG; r++) begin : g_row
    logic [DW-1:0] q;
    logic hit_a, hit_b;
    assign hit_a = wa_en && (wa_addr == RW'(r));
    assign hit_b = wb_en && (wb_addr == RW'(r));

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else begin
        for (int b = 0; b < NB; b++) begin
          if (hit_a && wa_be[b])
            q[b*8 +: 8] <= wa_data[b*8 +: 8];
          else if (hit_b && !hit_a)
            q[b*8 +: 8] <= wb_data[b*8 +: 8];
        end
      end
    end
    assign rows[r] = q;
  end

  assign ra_data = rows[ra_addr];
  assign rc_data = rows[rc_addr];

  always_ff @(posedge clk) begin
    if (rst) rx_data <= '0;
    else     rx_data <= rows[rx_addr];
  end

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_addr == '0) |=> (rx_data == '0));

endmodule

// File: rtl/ldw_agu.sv
module ldw_agu
  import ldw_pkg::*;
#(
  parameter int DW   = 16,
  parameter int OW   = 5,
  parameter int STEP = 2
) (
  input  amode_t        mode,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] index,
  input  logic [OW-1:0] offs,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] idx_next
);

  localparam logic [DW-1:0] STEP_W = DW'(STEP);

  logic [DW-1:0] idx_dec, idx_inc, offs_ext;

  assign idx_dec  = index - STEP_W;
  assign idx_inc  = index + STEP_W;
  assign offs_ext = {{(DW-OW){1'b0}}, offs};

  always_comb begin
    case (mode)
      AM_OFFS: begin
        ea       = base + offs_ext;
        idx_next = index;
      end
      AM_POSTINC: begin
        ea       = base + index;
        idx_next = idx_inc;
      end
      AM_PREDEC: begin
        ea       = base + idx_dec;
        idx_next = idx_dec;
      end
      default: begin
        ea       = base + index;
        idx_next = index;
      end
    endcase
  end

endmodule

// File: rtl/ldw_seq.sv
module ldw_seq
  import ldw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  output st_t               st,
  output amode_t            mode_q,
  output logic              accept,
  output logic              busy
);

  st_t nxt;

  assign accept = (st == ST_IDLE) && start && mode_ok(mode);

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:   if (accept) nxt = (amode_t'(mode) == AM_IMM) ? ST_IMM_LO : ST_ADDR;
      ST_ADDR:   nxt = ST_READ;
      ST_READ:   nxt = ST_WB;
      ST_WB:     nxt = ST_IDLE;
      ST_IMM_LO: nxt = ST_IMM_HI;
      ST_IMM_HI: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      mode_q <= AM_OFFS;
      busy   <= 1'b0;
    end else begin
      st   <= nxt;
      busy <= (nxt != ST_IDLE);
      if (accept) mode_q <= amode_t'(mode);
    end
  end

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mode_q));

  // R10
  wb_single_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WB) |=> (st == ST_IDLE));

endmodule

// File: rtl/ldw_exec_unit.sv
module ldw_exec_unit
  import ldw_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int OW   = 5,
  parameter int STEP = 2,
  localparam int RW  = $clog2(NREG),
  localparam int NB  = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [RW-1:0] rd_sel,
  input  logic [RW-1:0] rb_sel,
  input  logic [RW-1:0] ri_sel,
  input  logic [OW-1:0] offs,
  input  logic [DW-1:0] imm,
  output logic          busy,
  output logic          done,
  output logic          mem_rd_en,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic [RW-1:0] rf_raddr,
  output logic [DW-1:0] rf_rdata
);

  localparam logic [DW-1:0] STEP_W = DW'(STEP);
  localparam logic [NB-1:0] BE_LO  = NB'(1);

  st_t           st;
  amode_t        mode_q;
  logic          accept;
  logic [RW-1:0] rd_q, rb_q, ri_q;
  logic [OW-1:0] offs_q;
  logic [DW-1:0] imm_q;
  logic [DW-1:0] rb_val, ri_val, ea, idx_next;

  logic          wa_en, wb_en;
  logic [NB-1:0] wa_be;
  logic [DW-1:0] wa_data;

  ldw_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mode   (mode),
    .st     (st),
    .mode_q (mode_q),
    .accept (accept),
    .busy   (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      rb_q   <= '0;
      ri_q   <= '0;
      offs_q <= '0;
      imm_q  <= '0;
    end else if (accept) begin
      rd_q   <= rd_sel;
      rb_q   <= rb_sel;
      ri_q   <= ri_sel;
      offs_q <= offs;
      imm_q  <= imm;
    end
  end

  ldw_agu #(.DW(DW), .OW(OW), .STEP(STEP)) u_agu (
    .mode     (mode_q),
    .base     (rb_val),
    .index    (ri_val),
    .offs     (offs_q),
    .ea       (ea),
    .idx_next (idx_next)
  );

  // destination port: loaded word or one constant byte lane
  always_comb begin
    wa_en   = 1'b0;
    wa_be   = '1;
    wa_data = mem_rdata;
    case (st)
      ST_WB:     wa_en = 1'b1;
      ST_IMM_LO: begin wa_en = 1'b1; wa_be = BE_LO;  wa_data = imm_q; end
      ST_IMM_HI: begin wa_en = 1'b1; wa_be = ~BE_LO; wa_data = imm_q; end
      default:   wa_en = 1'b0;
    endcase
  end

  // index port: step down before the read, step up after it
  always_comb begin
    wb_en = 1'b0;
    if (st == ST_ADDR && mode_q == AM_PREDEC)
      wb_en = 1'b1;
    else if (st == ST_WB && mode_q == AM_POSTINC && ri_q != rd_q)
      wb_en = 1'b1;
  end

  ldw_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wa_en   (wa_en),
    .wa_addr (rd_q),
    .wa_be   (wa_be),
    .wa_data (wa_data),
    .wb_en   (wb_en),
    .wb_addr (ri_q),
    .wb_data (idx_next),
    .ra_addr (rb_q),
    .ra_data (rb_val),
    .rc_addr (ri_q),
    .rc_data (ri_val),
    .rx_addr (rf_raddr),
    .rx_data (rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      done      <= 1'b0;
    end else begin
      mem_rd_en <= (st == ST_ADDR);
      if (st == ST_ADDR) mem_addr <= ea;
      done      <= (st == ST_READ) || (st == ST_IMM_LO);
    end
  end

  // R10
  done_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> done);

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R6
  imm_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IMM_LO || st == ST_IMM_HI) |-> !mem_rd_en);

  // R3
  postinc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WB && mode_q == AM_POSTINC && ri_q != rd_q && ri_q != '0)
      |=> (ri_val == $past(ri_val) + STEP_W));

  // R4
  predec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR && mode_q == AM_PREDEC && ri_q != '0)
      |=> (ri_val == $past(ri_val) - STEP_W));

endmodule

// File: tb/sim_ldw_exec_unit.sv
module sim_ldw_exec_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [2:0]  rd_sel = '0, rb_sel = '0, ri_sel = '0;
  logic [4:0]  offs = '0;
  logic [15:0] imm = '0;
  logic        busy, done, mem_rd_en;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [2:0]  rf_raddr = '0;
  logic [15:0] rf_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] sh [8];
  logic [15:0] exp_q [$];

  always #10 clk = ~clk;   // 50 MHz

  ldw_exec_unit u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .rd_sel(rd_sel), .rb_sel(rb_sel), .ri_sel(ri_sel),
    .offs(offs), .imm(imm), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  function automatic logic [15:0] mword(input logic [15:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hA5};
  endfunction

  // synchronous memory model
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mword(mem_addr);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: every read on the port must match the next expected address
  always @(negedge clk) begin
    if (!rst && mem_rd_en) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11: actual read at %h expected no read", mem_addr);
      end else begin
        chk("R10 read address", mem_addr, exp_q.pop_front());
      end
    end
  end

  task automatic rdreg(input logic [2:0] a, output logic [15:0] v);
    rf_raddr = a;
    @(negedge clk);
    v = rf_rdata;
  endtask

  task automatic check_reg(input string req, input logic [2:0] a);
    logic [15:0] v;
    rdreg(a, v);
    chk(req, v, sh[a]);
  endtask

  // driver: predicts effects, pushes the expected address, runs the instruction
  task automatic run(input string req, input logic [2:0] m, input logic [2:0] d,
                     input logic [2:0] b, input logic [2:0] x,
                     input logic [4:0] o, input logic [15:0] k, input bit intrude);
    logic [15:0] ea, iv, old;
    int lat;
    bit is_imm;
    is_imm = (m == 3'd4);
    old = sh[d];
    iv  = sh[x];
    if (!is_imm) begin
      case (m)
        3'd0: ea = sh[b] + {11'd0, o};
        3'd3: ea = sh[b] + (iv - 16'd2);
        default: ea = sh[b] + iv;
      endcase
      exp_q.push_back(ea);
    end
    rf_raddr = d;
    start = 1'b1; mode = m; rd_sel = d; rb_sel = b; ri_sel = x; offs = o; imm = k;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      start = 1'b1; mode = 3'd4; rd_sel = 3'd5; imm = 16'hFFFF;
    end
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    start = 1'b0;
    chk({req, " R10 done latency"}, 16'(lat), is_imm ? 16'd2 : 16'd3);
    if (is_imm) begin
      @(negedge clk);
      // R6: low byte is in place before the high byte
      chk({req, " R6 byte order"}, rf_rdata, (d == 0) ? 16'h0 : {old[15:8], k[7:0]});
      if (d != 0) sh[d] = k;
    end else begin
      @(negedge clk);
      if (m == 3'd3 && x != 0) sh[x] = iv - 16'd2;
      if (m == 3'd2 && x != d && x != 0) sh[x] = iv + 16'd2;
      if (d != 0) sh[d] = mword(ea);
      check_reg({req, " index"}, x);
      check_reg({req, " base"}, b);
    end
    check_reg({req, " dest"}, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 8; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 busy", 16'(busy), 16'd0);
    chk("R12 done", 16'(done), 16'd0);
    chk("R12 mem_rd_en", 16'(mem_rd_en), 16'd0);
    for (int r = 1; r < 8; r++) check_reg("R12 reg", 3'(r));

    // constant loads set up the register file
    run("R6", 3'd4, 3'd1, 3'd0, 3'd0, 5'd0, 16'h1000, 1'b0);
    run("R6", 3'd4, 3'd2, 3'd0, 3'd0, 5'd0, 16'h0005, 1'b0);
    run("R6", 3'd4, 3'd3, 3'd0, 3'd0, 5'd0, 16'h00FF, 1'b0);
    run("R6", 3'd4, 3'd4, 3'd0, 3'd0, 5'd0, 16'hFFFE, 1'b0);
    run("R6", 3'd4, 3'd5, 3'd0, 3'd0, 5'd0, 16'h1234, 1'b0);
    run("R6", 3'd4, 3'd6, 3'd0, 3'd0, 5'd0, 16'hAAAA, 1'b0);
    run("R6", 3'd4, 3'd6, 3'd0, 3'd0, 5'd0, 16'h5A5A, 1'b0);
    run("R7", 3'd4, 3'd0, 3'd0, 3'd0, 5'd0, 16'hBEEF, 1'b0);

    run("R1 R9", 3'd0, 3'd6, 3'd1, 3'd2, 5'd31, 16'h0, 1'b0);
    run("R2", 3'd1, 3'd7, 3'd1, 3'd2, 5'd0, 16'h0, 1'b0);
    run("R3", 3'd2, 3'd6, 3'd1, 3'd3, 5'd0, 16'h0, 1'b0);
    run("R4", 3'd3, 3'd7, 3'd1, 3'd2, 5'd0, 16'h0, 1'b0);
    run("R5", 3'd2, 3'd3, 3'd1, 3'd3, 5'd0, 16'h0, 1'b0);
    run("R8", 3'd0, 3'd6, 3'd4, 3'd2, 5'd4, 16'h0, 1'b0);
    run("R8", 3'd4, 3'd7, 3'd0, 3'd0, 5'd0, 16'h0000, 1'b0);
    run("R8", 3'd3, 3'd6, 3'd1, 3'd7, 5'd0, 16'h0, 1'b0);
    run("R7", 3'd0, 3'd0, 3'd1, 3'd2, 5'd2, 16'h0, 1'b0);

    // R11: start during busy is dropped; r5 must keep its value
    run("R11", 3'd1, 3'd6, 3'd1, 3'd2, 5'd0, 16'h0, 1'b1);
    check_reg("R11 r5 untouched", 3'd5);

    // R11: undefined mode code is dropped
    start = 1'b1; mode = 3'd5; rd_sel = 3'd2; rb_sel = 3'd1; ri_sel = 3'd1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 undefined mode busy", 16'(busy), 16'd0);
    repeat (4) @(negedge clk);
    check_reg("R11 undefined mode r2", 3'd2);

    chk("R10 all reads seen", 16'(exp_q.size()), 16'd0);
    rdreg(3'd0, v);
    chk("R7 r0 zero", v, 16'h0);
    summary();
  end

endmodule